// File: doc/BRIEF.md
# Serial Shift Clock Generator

This block produces the basic clock enable of a serial channel, plus the shift clock that goes out on the clock pin and the strobe that tells the receive path when to sample its data pin. In asynchronous mode a 2-bit select picks one of four tick sources. The sources are the baud generator tick, every system clock cycle, an internal timer tick, or a rising edge on the external clock pin.

In synchronous mode the block works in one of two ways. As clock master, it halves the baud tick to toggle a shift clock that idles high. As clock slave, it passes the external shift clock through a synchronizer and detects the edge chosen by an edge-select bit.

Every output is a registered single-cycle enable in the system clock domain. The only exception is the shift clock level, which is a registered level that drives the clock pin.

Top module: `sclk_gen`

## Requirements
- R1: While rst_ni is low, base_en_o and sample_en_o are 0 and sclk_o is 1.
- R2: With sync_mode_i=0, base_en_o in cycle n+1 equals the tick picked in cycle n by src_sel_i. The encodings are 0 = baud_tick_i, 1 = every cycle, 2 = timer_tick_i, and 3 = a synchronized rising edge of sclk_i. For source 3, a pin change appears on base_en_o three clock edges later.
- R3: With sync_mode_i=0, sample_en_o stays 0 and sclk_o stays 1.
- R4: In master mode (sync_mode_i=1, clk_dir_i=0) with xfer_active_i=1, each baud_tick_i toggles sclk_o on the next edge. base_en_o pulses together with every low-to-high toggle, which is once per two ticks.
- R5: In master mode, sample_en_o pulses in exactly the cycle in which sclk_o has just fallen.
- R6: In master mode with xfer_active_i=0, sclk_o returns to 1 on the next edge and neither enable pulses.
- R7: In slave mode (sync_mode_i=1, clk_dir_i=1), base_en_o and sample_en_o pulse together for a rising edge of sclk_i when edge_sel_i=0, and for a falling edge when edge_sel_i=1. The pulse comes three clock edges after the pin change.
- R8: In slave mode sclk_o stays 1 and baud_tick_i has no effect on either enable.
- R9: A single edge of sclk_i in slave mode yields exactly one cycle of base_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1 = synchronous I/O, 0 = asynchronous |
| clk_dir_i | input | 1 | Synchronous mode: 0 = drive clock, 1 = receive clock |
| edge_sel_i | input | 1 | Slave edge: 0 = rising, 1 = falling |
| src_sel_i | input | 2 | Asynchronous tick source select |
| xfer_active_i | input | 1 | Master transfer in progress |
| baud_tick_i | input | 1 | Baud generator tick |
| timer_tick_i | input | 1 | Internal timer tick |
| sclk_i | input | 1 | External clock pin (asynchronous) |
| base_en_o | output | 1 | Basic clock enable |
| sclk_o | output | 1 | Shift clock level driven out |
| sample_en_o | output | 1 | Data pin sample strobe |

## Verification
The bench builds the block with its default of two synchronizer stages. Its reference model is written for exactly this latency, so edge-to-enable timing is checked to the cycle. Random tick and pin patterns in each of the three modes reach several corner cases. These include back-to-back baud ticks, pin toggles on consecutive cycles, a transfer dropped mid-period, and switches of the edge select.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  typedef enum logic [1:0] {
    SRC_BAUD  = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_TIMER = 2'd2,
    SRC_EXT   = 2'd3
  } src_sel_e;

  typedef enum logic [1:0] {
    MODE_ASYNC  = 2'd0,
    MODE_MASTER = 2'd1,
    MODE_SLAVE  = 2'd2
  } op_mode_e;

  localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/sclk_edge_det.sv
module sclk_edge_det #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= RESET_VAL;
          else         sync_q[i] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= RESET_VAL;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RESET_VAL;
    else         prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;
  assign fall_o = ~sync_q[LAST] & prev_q;
endmodule

// File: rtl/sclk_src_mux.sv
module sclk_src_mux
  import sclk_gen_pkg::*;
(
  input  src_sel_e           sel_i,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic               tick_o
);
  logic [NUM_SRC-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = tick_i[i] & (sel_i == src_sel_e'(i));
    end
  endgenerate

  assign tick_o = |hit;
endmodule

// File: rtl/sclk_master_div.sv
module sclk_master_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic active_i,
  input  logic tick_i,
  output logic sclk_o,
  output logic rise_nx_o,
  output logic fall_nx_o
);
  logic sclk_q;
  logic toggle;

  assign toggle = run_i & active_i & tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sclk_q <= 1'b1;
    else if (!(run_i & active_i)) sclk_q <= 1'b1;  // idle high
    else if (tick_i)             sclk_q <= ~sclk_q;
  end

  assign rise_nx_o = toggle & ~sclk_q;
  assign fall_nx_o = toggle & sclk_q;
  assign sclk_o    = sclk_q;
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_gen_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_mode_i,
  input  logic       clk_dir_i,
  input  logic       edge_sel_i,
  input  logic [1:0] src_sel_i,
  input  logic       xfer_active_i,
  input  logic       baud_tick_i,
  input  logic       timer_tick_i,
  input  logic       sclk_i,
  output logic       base_en_o,
  output logic       sclk_o,
  output logic       sample_en_o
);
  op_mode_e           mode;
  logic               ext_rise, ext_fall;
  logic [NUM_SRC-1:0] ticks;
  logic               async_tick;
  logic               m_rise_nx, m_fall_nx;
  logic               base_d, samp_d;
  logic               base_q, samp_q;
  logic               slave_edge;

  always_comb begin
    if (!sync_mode_i)    mode = MODE_ASYNC;
    else if (!clk_dir_i) mode = MODE_MASTER;
    else                 mode = MODE_SLAVE;
  end

  sclk_edge_det #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (sclk_i),
    .rise_o(ext_rise),
    .fall_o(ext_fall)
  );

  assign ticks[SRC_BAUD]  = baud_tick_i;
  assign ticks[SRC_SYS]   = 1'b1;
  assign ticks[SRC_TIMER] = timer_tick_i;
  assign ticks[SRC_EXT]   = ext_rise;

  sclk_src_mux u_mux (
    .sel_i (src_sel_e'(src_sel_i)),
    .tick_i(ticks),
    .tick_o(async_tick)
  );

  sclk_master_div u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (mode == MODE_MASTER),
    .active_i (xfer_active_i),
    .tick_i   (baud_tick_i),
    .sclk_o   (sclk_o),
    .rise_nx_o(m_rise_nx),
    .fall_nx_o(m_fall_nx)
  );

  assign slave_edge = edge_sel_i ? ext_fall : ext_rise;

  always_comb begin
    base_d = 1'b0;
    samp_d = 1'b0;
    unique case (mode)
      MODE_ASYNC:  base_d = async_tick;
      MODE_MASTER: begin
        base_d = m_rise_nx;
        samp_d = m_fall_nx;   // data sampled as the driven clock falls
      end
      MODE_SLAVE: begin
        base_d = slave_edge;
        samp_d = slave_edge;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      base_q <= base_d;
      samp_q <= samp_d;
    end
  end

  assign base_en_o   = base_q;
  assign sample_en_o = samp_q;
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_mode_i,
  input logic clk_dir_i,
  input logic edge_sel_i,
  input logic xfer_active_i,
  input logic baud_tick_i,
  input logic base_en_o,
  input logic sclk_o,
  input logic sample_en_o
);
  AST_ASYNC_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(sync_mode_i)) |-> !sample_en_o); // R3

  AST_IDLE_SCLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!sync_mode_i || clk_dir_i || !xfer_active_i)) |-> sclk_o); // R6

  AST_MASTER_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sync_mode_i && !clk_dir_i && xfer_active_i && baud_tick_i))
      |-> (sclk_o != $past(sclk_o))); // R4

  AST_SAMPLE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $fell(sclk_o)) |-> sample_en_o); // R5

  AST_SLAVE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sync_mode_i && clk_dir_i)) |-> (base_en_o == sample_en_o)); // R7

  AST_SLAVE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sync_mode_i && clk_dir_i) && sync_mode_i && clk_dir_i &&
     $stable(edge_sel_i) && base_en_o) |=> !base_en_o); // R9
endmodule

bind sclk_gen sclk_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_mode_i  (sync_mode_i),
  .clk_dir_i    (clk_dir_i),
  .edge_sel_i   (edge_sel_i),
  .xfer_active_i(xfer_active_i),
  .baud_tick_i  (baud_tick_i),
  .base_en_o    (base_en_o),
  .sclk_o       (sclk_o),
  .sample_en_o  (sample_en_o)
);

// File: tb/tb_sclk_gen.sv
module tb_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_mode_i = 1'b0, clk_dir_i = 1'b0, edge_sel_i = 1'b0;
  logic [1:0] src_sel_i = 2'd0;
  logic       xfer_active_i = 1'b0, baud_tick_i = 1'b0, timer_tick_i = 1'b0;
  logic       sclk_i = 1'b1;
  logic       base_en_o, sclk_o, sample_en_o;

  int checks = 0;
  int fails  = 0;

  // reference model state
  bit h0 = 1, h1 = 1, h2 = 1;
  bit m_sclk = 1;
  bit e_base = 0, e_samp = 0, e_sclk = 1;
  string tag_b, tag_s, tag_c;

  always #2 clk = ~clk;

  sclk_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_mode_i(sync_mode_i), .clk_dir_i(clk_dir_i),
    .edge_sel_i(edge_sel_i), .src_sel_i(src_sel_i), .xfer_active_i(xfer_active_i),
    .baud_tick_i(baud_tick_i), .timer_tick_i(timer_tick_i), .sclk_i(sclk_i),
    .base_en_o(base_en_o), .sclk_o(sclk_o), .sample_en_o(sample_en_o)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model();
    bit rise, fall;
    rise = h1 & ~h2;
    fall = ~h1 & h2;
    e_base = 0; e_samp = 0;
    if (!sync_mode_i) begin
      tag_b = "R2"; tag_s = "R3"; tag_c = "R3";
      case (src_sel_i)
        2'd0: e_base = baud_tick_i;
        2'd1: e_base = 1;
        2'd2: e_base = timer_tick_i;
        default: e_base = rise;
      endcase
      m_sclk = 1;
    end else if (!clk_dir_i) begin
      if (!xfer_active_i) begin
        tag_b = "R6"; tag_s = "R6"; tag_c = "R6";
        m_sclk = 1;
      end else begin
        tag_b = "R4"; tag_s = "R5"; tag_c = "R4";
        if (baud_tick_i) begin
          e_base = (m_sclk == 0);
          e_samp = (m_sclk == 1);
          m_sclk = ~m_sclk;
        end
      end
    end else begin
      tag_b = "R7"; tag_s = "R7"; tag_c = "R8";
      e_base = edge_sel_i ? fall : rise;
      e_samp = e_base;
      m_sclk = 1;
    end
    e_sclk = m_sclk;
    h2 = h1; h1 = h0; h0 = sclk_i;
  endtask

  task automatic cyc();
    @(posedge clk);
    model();
    @(negedge clk);
    check(tag_b, base_en_o, e_base);
    check(tag_s, sample_en_o, e_samp);
    check(tag_c, sclk_o, e_sclk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int pulses;
    // R1: reset state
    repeat (3) @(negedge clk);
    baud_tick_i = 1; timer_tick_i = 1; sync_mode_i = 1; xfer_active_i = 1;
    @(negedge clk);
    check("R1", base_en_o, 1'b0);
    check("R1", sample_en_o, 1'b0);
    check("R1", sclk_o, 1'b1);
    baud_tick_i = 0; timer_tick_i = 0; sync_mode_i = 0; xfer_active_i = 0;
    @(negedge clk);
    rst_ni = 1'b1;

    // R2, R3: asynchronous mode, every source
    for (int s = 0; s < 4; s++) begin
      src_sel_i = s[1:0];
      for (int n = 0; n < 200; n++) begin
        baud_tick_i  = ($urandom_range(0, 3) == 0);
        timer_tick_i = ($urandom_range(0, 2) == 0);
        if ($urandom_range(0, 3) == 0) sclk_i = ~sclk_i;
        cyc();
      end
    end

    // R4, R5, R6: master mode with transfers started and dropped
    sync_mode_i = 1; clk_dir_i = 0; sclk_i = 1;
    for (int n = 0; n < 1200; n++) begin
      baud_tick_i = ($urandom_range(0, 2) != 0);
      if (n % 150 == 0) xfer_active_i = ~xfer_active_i;
      if (n % 97 == 50) xfer_active_i = 0;
      cyc();
    end
    baud_tick_i = 1; xfer_active_i = 1;
    repeat (20) cyc();

    // R7, R8: slave mode, both edges, baud ticks present
    clk_dir_i = 1; xfer_active_i = 1;
    for (int n = 0; n < 1200; n++) begin
      baud_tick_i = ($urandom_range(0, 1) == 0);
      if ($urandom_range(0, 2) == 0) sclk_i = ~sclk_i;
      if (n % 300 == 299) edge_sel_i = ~edge_sel_i;
      cyc();
    end

    // R9: single falling edge, count enable cycles
    edge_sel_i = 1; sclk_i = 1;
    repeat (6) cyc();
    sclk_i = 0;
    pulses = 0;
    for (int n = 0; n < 8; n++) begin
      cyc();
      if (base_en_o) pulses++;
    end
    check("R9", (pulses == 1), 1'b1);

    summary();
    $finish;
  end
endmodule